// File: doc/BRIEF.md
# Multi-Link Interrupt Status Controller

This block holds the interrupt status and interrupt enable registers for eight receive links. Each link has one status byte and one enable byte. Single-cycle event pulses from the link detectors set sticky status bits. Overflow levels from the link's counters and receive FIFO are folded into one status bit that follows its sources and is never latched. Link 0 has two extra group-level bits in its top positions.

Software reads the registers, clears sticky bits by writing 0 to them, and masks or re-arms sources through the enable byte. A single active-high interrupt output is the registered OR of every status bit whose enable bit is set. Masking a source does not stop it from latching, so a pending condition raises the interrupt as soon as that source is enabled again.

Top module: `link_irq_bank`

## Requirements
- R1: After reset every sticky status bit, every enable bit, `irq` and `rdata` are 0.
- R2: A one-cycle pulse on `evt_pulse[5*n+k]` (k = 0..4) sets status bit k+1 of link n at the next clock edge, and the bit stays set after the pulse ends.
- R3: A status write clears each sticky bit whose `wdata` bit is 0; a sticky bit whose `wdata` bit is 1 is left unchanged.
- R4: Status bit 0 of link n is the OR of the 13 levels `ovf_lvl[13*n+12 : 13*n]`; it is never latched, drops when those levels drop, and no status write changes it.
- R5: Reading a status register leaves its contents unchanged.
- R6: When a set pulse and a write that clears the same sticky bit arrive in the same cycle, the bit ends up set.
- R7: An enable write stores `wdata` into the enable byte of the addressed link; link 0 keeps all 8 bits, links 1 to 7 keep bits 5:0 and read bits 7:6 as 0.
- R8: `irq` is 1 exactly one clock after some link has a status bit set together with its enable bit, and 0 one clock after no such pair exists.
- R9: Events still latch while their enable bit is 0 without raising `irq`; writing the enable bit to 1 raises `irq` one clock after the write.
- R10: In link 0, status bit 7 is the OR of the four `grp_ovf_lvl` levels and ignores writes; status bit 6 is sticky, set by a `grp_xfer_done` or `grp_frame_end` pulse and cleared by writing 0; links 1 to 7 read bits 7:6 of status as 0.
- R11: `addr[3]` selects status (0) or enable (1) and `addr[2:0]` selects the link; `rd_en` loads the selected byte into `rdata` at the clock edge, and `rdata` holds its value while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 40 | Five event pulses per link, link n at bits 5n+4..5n |
| ovf_lvl | input | 104 | Thirteen overflow levels per link, link n at bits 13n+12..13n |
| grp_ovf_lvl | input | 4 | Group overflow levels, summarised in link 0 bit 7 |
| grp_xfer_done | input | 1 | Transfer-complete pulse, sets link 0 bit 6 |
| grp_frame_end | input | 1 | End-of-frame pulse, sets link 0 bit 6 |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 4 | Register select: bit 3 kind, bits 2:0 link |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered active-high interrupt |

## Verification
On every cycle the assertions check that a sticky bit only falls after a write that cleared it, that a set pulse always leaves its bit set (covering the collision with a clear), and that `irq` follows the enabled status of the previous cycle in both directions. The bench scenarios are needed for what the assertions cannot see from inside one link cell: the address decode and registered read path, the non-latched overflow bits and their immunity to writes, the enable width per link, reads having no side effect, and the masked-then-re-armed interrupt sequence.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
    parameter int NLINK   = 8;
    parameter int EVT_W   = 5;
    parameter int OVF_W   = 13;
    parameter int NGRP    = 4;
    parameter int REG_W   = 8;
    localparam int LINK_AW = $clog2(NLINK);
    localparam int ADDR_W  = LINK_AW + 1;

    // status byte layout
    typedef struct packed {
        logic             grp_ovf;
        logic             grp_evt;
        logic [EVT_W-1:0] evt;
        logic             ovf;
    } stat_t;

    typedef enum logic {SEL_STAT = 1'b0, SEL_EN = 1'b1} sel_e;

    // bits that behave as sticky latches
    function automatic logic [REG_W-1:0] latch_mask(input bit ext);
        logic [REG_W-1:0] m;
        m = '0;
        m[EVT_W:1] = '1;
        m[REG_W-2] = ext;
        return m;
    endfunction

    // bits the enable register keeps
    function automatic logic [REG_W-1:0] en_mask(input bit ext);
        logic [REG_W-1:0] m;
        m = '0;
        m[EVT_W:0] = '1;
        m[REG_W-1:REG_W-2] = {ext, ext};
        return m;
    endfunction
endpackage

// File: rtl/link_stat_cell.sv
module link_stat_cell
    import irq_bank_pkg::*;
#(
    parameter bit EXT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt,
    input  logic [OVF_W-1:0] ovf,
    input  logic             grp_ovf_any,
    input  logic             grp_evt,
    input  logic             stat_wr,
    input  logic             en_wr,
    input  logic [REG_W-1:0] wdata,
    output stat_t            stat,
    output logic [REG_W-1:0] en
);
    localparam logic [REG_W-1:0] LMASK = latch_mask(EXT);
    localparam logic [REG_W-1:0] EMASK = en_mask(EXT);

    logic [REG_W-1:0] lat;
    logic [REG_W-1:0] set_v;
    logic [REG_W-1:0] clr_v;

    always_comb begin
        set_v = {1'b0, grp_evt & EXT, evt, 1'b0} & LMASK;
        clr_v = stat_wr ? (~wdata & LMASK) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat <= '0;
            en  <= '0;
        end else begin
            lat <= ((lat & ~clr_v) | set_v) & LMASK;
            if (en_wr) en <= wdata & EMASK;
        end
    end

    always_comb begin
        stat         = stat_t'(lat);
        stat.ovf     = |ovf;
        stat.grp_ovf = grp_ovf_any & EXT;
    end

    // R3
    sticky_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(lat) & ~lat & ~$past(clr_v)) == '0));

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ((lat & $past(set_v)) == $past(set_v)));
endmodule

// File: rtl/irq_merge.sv
module irq_merge
    import irq_bank_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NLINK-1:0][REG_W-1:0] stat_all,
    input  logic [NLINK-1:0][REG_W-1:0] en_all,
    output logic                       irq
);
    logic [NLINK-1:0] hit;

    always_comb begin
        for (int i = 0; i < NLINK; i++) hit[i] = |(stat_all[i] & en_all[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |hit;
    end

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> irq);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(|hit) |=> !irq);
endmodule

// File: rtl/link_irq_bank.sv
module link_irq_bank
    import irq_bank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NLINK*EVT_W-1:0]   evt_pulse,
    input  logic [NLINK*OVF_W-1:0]   ovf_lvl,
    input  logic [NGRP-1:0]          grp_ovf_lvl,
    input  logic                     grp_xfer_done,
    input  logic                     grp_frame_end,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [REG_W-1:0]         wdata,
    output logic [REG_W-1:0]         rdata,
    output logic                     irq
);
    logic [NLINK-1:0][REG_W-1:0] stat_all;
    logic [NLINK-1:0][REG_W-1:0] en_all;
    sel_e                        sel;
    logic [LINK_AW-1:0]          lsel;

    assign sel  = sel_e'(addr[ADDR_W-1]);
    assign lsel = addr[LINK_AW-1:0];

    for (genvar i = 0; i < NLINK; i++) begin : g_link
        stat_t st;
        logic  wr_hit;
        assign wr_hit = wr_en && (lsel == LINK_AW'(i));
        link_stat_cell #(.EXT(i == 0)) u_cell (
            .clk         (clk),
            .rst         (rst),
            .evt         (evt_pulse[i*EVT_W +: EVT_W]),
            .ovf         (ovf_lvl[i*OVF_W +: OVF_W]),
            .grp_ovf_any (|grp_ovf_lvl),
            .grp_evt     (grp_xfer_done | grp_frame_end),
            .stat_wr     (wr_hit && sel == SEL_STAT),
            .en_wr       (wr_hit && sel == SEL_EN),
            .wdata       (wdata),
            .stat        (st),
            .en          (en_all[i])
        );
        assign stat_all[i] = REG_W'(st);
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= (sel == SEL_EN) ? en_all[lsel] : stat_all[lsel];
    end

    irq_merge u_merge (
        .clk      (clk),
        .rst      (rst),
        .stat_all (stat_all),
        .en_all   (en_all),
        .irq      (irq)
    );

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> $stable(rdata));
endmodule

// File: tb/sim_link_irq_bank.sv
module sim_link_irq_bank;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst;
    logic [39:0]  evt_pulse;
    logic [103:0] ovf_lvl;
    logic [3:0]   grp_ovf_lvl;
    logic         grp_xfer_done, grp_frame_end;
    logic         wr_en, rd_en;
    logic [3:0]   addr;
    logic [7:0]   wdata;
    logic [7:0]   rdata;
    logic         irq;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_irq_bank u0 (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .ovf_lvl(ovf_lvl),
        .grp_ovf_lvl(grp_ovf_lvl), .grp_xfer_done(grp_xfer_done),
        .grp_frame_end(grp_frame_end), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; evt_pulse = '0; ovf_lvl = '0; grp_ovf_lvl = '0;
        grp_xfer_done = 1'b0; grp_frame_end = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int link, input int k);
        @(negedge clk);
        evt_pulse[link*5 + k] = 1'b1;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 rdata", rdata, 8'h00);
        rd(4'h3, v); chk("R1 status", v, 8'h00);
        rd(4'h8, v); chk("R1 enable", v, 8'h00);
    endtask

    task automatic t_latch();
        logic [7:0] v;
        do_reset();
        pulse(3, 2);
        rd(4'h3, v); chk("R2 latch", v, 8'h08);
        rd(4'h3, v); chk("R5 reread", v, 8'h08);
        rd(4'h2, v); chk("R11 other link", v, 8'h00);
    endtask

    task automatic t_clear();
        logic [7:0] v;
        do_reset();
        @(negedge clk);
        evt_pulse[3*5 + 0] = 1'b1; evt_pulse[3*5 + 3] = 1'b1;
        @(negedge clk);
        evt_pulse = '0;
        rd(4'h3, v); chk("R2 two bits", v, 8'h12);
        wr(4'h3, 8'hFD);
        rd(4'h3, v); chk("R3 clear bit1", v, 8'h10);
        wr(4'h3, 8'hFF);
        rd(4'h3, v); chk("R3 write1 no effect", v, 8'h10);
    endtask

    task automatic t_ovf();
        logic [7:0] v;
        do_reset();
        @(negedge clk); ovf_lvl[5*13 + 7] = 1'b1;
        rd(4'h5, v); chk("R4 ovf set", v, 8'h01);
        wr(4'h5, 8'h00);
        rd(4'h5, v); chk("R4 write0 no effect", v, 8'h01);
        @(negedge clk); ovf_lvl = '0;
        rd(4'h5, v); chk("R4 ovf drops", v, 8'h00);
    endtask

    task automatic t_setwins();
        logic [7:0] v;
        do_reset();
        @(negedge clk);
        evt_pulse[2*5 + 4] = 1'b1;
        wr_en = 1'b1; addr = 4'h2; wdata = 8'h00;
        @(negedge clk);
        evt_pulse = '0; wr_en = 1'b0;
        rd(4'h2, v); chk("R6 set wins", v, 8'h20);
    endtask

    task automatic t_enable();
        logic [7:0] v;
        do_reset();
        wr(4'h9, 8'hFF);
        rd(4'h9, v); chk("R7 link1 enable", v, 8'h3F);
        wr(4'h8, 8'hFF);
        rd(4'h8, v); chk("R7 link0 enable", v, 8'hFF);
        wr(4'hF, 8'h05);
        rd(4'hF, v); chk("R7 link7 enable", v, 8'h05);
    endtask

    task automatic t_irq();
        do_reset();
        wr(4'hE, 8'h04);
        pulse(6, 1);
        chk("R8 irq latency", {7'b0, irq}, 8'h00);
        @(negedge clk);
        chk("R8 irq raised", {7'b0, irq}, 8'h01);
        wr(4'h6, 8'h00);
        @(negedge clk);
        chk("R8 irq cleared", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_masked();
        logic [7:0] v;
        do_reset();
        pulse(4, 4);
        repeat (2) @(negedge clk);
        chk("R9 masked no irq", {7'b0, irq}, 8'h00);
        rd(4'h4, v); chk("R9 latched while masked", v, 8'h20);
        wr(4'hC, 8'h20);
        chk("R9 rearm latency", {7'b0, irq}, 8'h00);
        @(negedge clk);
        chk("R9 rearm irq", {7'b0, irq}, 8'h01);
    endtask

    task automatic t_group();
        logic [7:0] v;
        do_reset();
        @(negedge clk); grp_ovf_lvl[2] = 1'b1;
        rd(4'h0, v); chk("R10 bit7", v, 8'h80);
        @(negedge clk); grp_xfer_done = 1'b1;
        @(negedge clk); grp_xfer_done = 1'b0;
        rd(4'h0, v); chk("R10 bit6 xfer", v, 8'hC0);
        wr(4'h0, 8'h00);
        rd(4'h0, v); chk("R10 clear bit6 keep bit7", v, 8'h80);
        @(negedge clk); grp_frame_end = 1'b1;
        @(negedge clk); grp_frame_end = 1'b0;
        grp_ovf_lvl = '0;
        rd(4'h0, v); chk("R10 bit6 frame end", v, 8'h40);
        rd(4'h1, v); chk("R10 link1 top bits", v, 8'h00);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: got %0d cycles expected < %0d", cycles, WATCHDOG);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_latch();
        t_clear();
        t_ovf();
        t_setwins();
        t_enable();
        t_irq();
        t_masked();
        t_group();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule